// File: doc/BRIEF.md
# Runtime-Partitioned Lane Reduction Unit

This unit folds an operand down to one bit per lane using parity, any-set or all-set logic. The caller divides the operand into independent lanes for each operation with a cut mask. A single datapath therefore serves one 64-bit lane, two 32-bit lanes, four 16-bit lanes, eight 8-bit lanes, or any uneven grouping of 8-bit chunks the mask describes.

The design first reduces each 8-bit chunk on its own. A running value then travels upward through the chunks and stops at every cut. The last value of each lane is copied back down onto every chunk slot that lane covers. The result holds one bit per chunk. By default it is registered, which gives one cycle of latency.

Top module: `simd_lane_reduce`

## Requirements
- R1: `WIDTH` sets the operand width, with 8-bit chunks by default. It gives `WIDTH/8` result bits and `WIDTH/8-1` cut bits. Both 64-bit (7 cuts) and 32-bit (3 cuts) builds behave as the other requirements describe.
- R2: `op_sel` picks the reduction: 2'b00 is parity (XOR of all lane bits), 2'b01 is any (OR), 2'b10 is all (AND) and 2'b11 is boolean nonzero. An all-zero operand gives all-zero results for every code. An all-ones operand gives all-zero results under parity and all-one results under the other codes.
- R3: `cut_mask[i]` = 1 places a lane boundary between chunk i (bits 8i+7..8i) and chunk i+1. When the bit is 0, those two chunks share a lane. Bits on one side of a cut never affect results on the other side.
- R4: With every cut bit set, `result[i]` is the reduction of chunk i alone.
- R5: With every cut bit clear, every result bit is the reduction of the whole operand.
- R6: Every result bit belonging to one lane carries that lane's value, so neighbouring slots with no cut between them are equal.
- R7: Irregular, non-power-of-two lane groupings are reduced exactly as the mask defines them, for all 2^(WIDTH/8-1) masks.
- R8: With `OUT_REG` = 1, `result` appears one clock after the inputs are presented, and it is all zero while `rst_n` is low.
- R9: Code 2'b11 gives the same result as code 2'b01 for every operand and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| operand | input | WIDTH | Data to reduce |
| cut_mask | input | WIDTH/8-1 | Lane boundary after each chunk, 1 = cut |
| op_sel | input | 2 | Reduction select |
| result | output | WIDTH/8 | Per-chunk lane result |

## Verification
The hardest cases to reach are irregular lanes, such as a 24-bit lane next to a 40-bit lane. Here a fault in the chain or the broadcast shows up only on some of the slots. The stimulus sweeps all 128 masks, and the 32-bit build sees the low three bits of each one. Under every mask it applies all four codes with zero, all-ones, single-bit and random operands. Single-bit operands are placed so that the set bit lands in a different chunk as the mask changes, which exposes leakage across a cut.

// File: rtl/simd_lane_reduce.sv
`timescale 1ns/1ps
module simd_lane_reduce #(
  parameter int WIDTH   = 64,
  parameter int CHUNK   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         operand,
  input  logic [WIDTH/CHUNK-2:0]   cut_mask,
  input  logic [1:0]               op_sel,
  output logic [WIDTH/CHUNK-1:0]   result
);
  localparam int NCH = WIDTH / CHUNK;
  localparam logic [1:0] OP_XOR = 2'b00;
  localparam logic [1:0] OP_AND = 2'b10;

  logic [NCH-1:0] part, acc, fin;

  function automatic logic merge(input logic a, input logic b, input logic [1:0] op);
    if (op == OP_XOR)      return a ^ b;
    else if (op == OP_AND) return a & b;
    else                   return a | b;
  endfunction

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (op_sel == OP_XOR)      part[i] = ^operand[i*CHUNK +: CHUNK];
      else if (op_sel == OP_AND) part[i] = &operand[i*CHUNK +: CHUNK];
      else                       part[i] = |operand[i*CHUNK +: CHUNK];
    end
    acc[0] = part[0];
    for (int i = 1; i < NCH; i++)
      acc[i] = cut_mask[i-1] ? part[i] : merge(acc[i-1], part[i], op_sel);
    fin[NCH-1] = acc[NCH-1];
    for (int i = NCH-2; i >= 0; i--)
      fin[i] = cut_mask[i] ? acc[i] : fin[i+1];
  end

  generate
    if (OUT_REG) begin : g_reg
      logic primed;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result <= '0;
          primed <= 1'b0;
        end else begin
          result <= fin;
          primed <= 1'b1;
        end
      end

      for (genvar i = 0; i < NCH-1; i++) begin : g_uni
        assert_lane_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
          primed && !$past(cut_mask[i]) |-> result[i] == result[i+1]);
      end

      assert_zero_operand_R2: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(operand) == '0 |-> result == '0);

      assert_ones_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(&operand) && $past(op_sel) == OP_XOR |-> result == '0);

      assert_ones_other_R2: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(&operand) && $past(op_sel) != OP_XOR |-> &result);
    end else begin : g_comb
      assign result = fin;
    end
  endgenerate
endmodule

// File: tb/tb_simd_lane_reduce.sv
`timescale 1ns/1ps
module tb_simd_lane_reduce;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] operand = '0;
  logic [6:0]  cut = '0;
  logic [1:0]  op = '0;
  logic [7:0]  res64;
  logic [3:0]  res32;
  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  simd_lane_reduce #(.WIDTH(64)) dut (
    .clk(clk), .rst_n(rst_n), .operand(operand), .cut_mask(cut),
    .op_sel(op), .result(res64));

  simd_lane_reduce #(.WIDTH(32)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .operand(operand[31:0]), .cut_mask(cut[2:0]),
    .op_sel(op), .result(res32));

  function automatic logic [7:0] model(input logic [63:0] v, input logic [6:0] m,
                                       input logic [1:0] o, input int nch);
    logic [7:0] r = '0;
    for (int s = 0; s < nch; s++) begin
      int lo = s;
      int hi = s;
      logic bitv;
      while (lo > 0 && !m[lo-1]) lo--;
      while (hi < nch-1 && !m[hi]) hi++;
      bitv = (o == 2'b10);
      for (int b = lo*8; b < (hi+1)*8; b++) begin
        if (o == 2'b00)      bitv = bitv ^ v[b];
        else if (o == 2'b10) bitv = bitv & v[b];
        else                 bitv = bitv | v[b];
      end
      r[s] = bitv;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h (mask %b op %b operand %h)",
               req, got, exp, cut, op, operand);
    end
  endtask

  // R3, R6 and R7 are covered by every mask; R1 by the narrow instance; R8 by the one-cycle sample
  task automatic apply(input logic [63:0] v, input logic [6:0] m, input logic [1:0] o);
    string tag;
    @(negedge clk);
    operand = v; cut = m; op = o;
    @(negedge clk);
    if (m == 7'h7F)      tag = "R4";
    else if (m == 7'h00) tag = "R5";
    else if (o == 2'b11) tag = "R9";
    else                 tag = "R7";
    check(tag, res64, model(v, m, o, 8));
    check("R1", {4'h0, res32}, model({32'h0, v[31:0]}, {4'h0, m[2:0]}, o, 4));
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    operand = {32'hFFFF_FFFF, 32'hFFFF_FFFF};
    op = 2'b10;
    repeat (3) @(negedge clk);
    check("R8", res64, 8'h00);
    check("R8", {4'h0, res32}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    for (int m = 0; m < 128; m++) begin
      for (int o = 0; o < 4; o++) begin
        apply(64'h0, 7'(m), 2'(o));
        apply({64{1'b1}}, 7'(m), 2'(o));
        apply(64'h1 << ((m*5 + o*17) % 64), 7'(m), 2'(o));
        apply(64'h1 << ((m*3 + o*11) % 32), 7'(m), 2'(o));
        for (int k = 0; k < 3; k++)
          apply({$urandom, $urandom}, 7'(m), 2'(o));
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule